// File: doc/BRIEF.md
# Receiver Acquisition Sequencer for a 4-Level FSK Modem

This block overrides the operating modes of a 4-level FSK receiver for a short time after software asks for fast acquisition. It has two sequences that run independently. The level sequence drives the mode select of the amplitude and offset measurement circuit. The clock sequence drives the bandwidth select of the symbol-timing PLL. Each sequence starts on its own one-cycle trigger pulse. It steps through its phases by counting symbol strobes. When it finishes, it hands the select back to the value that software holds on its mode inputs.

The level sequence has three phases. It clamps, then runs a fast lossy peak detect, then a slow peak detect. The slow phase has no time limit and ends only when a frame-sync pulse arrives. The clock sequence uses an extra-wide PLL bandwidth first. Software cannot request that bandwidth. The sequence then uses the wide bandwidth and ends after a fixed number of symbols.

While the level sequence runs, the block also watches the received symbol stream. It raises a ready flag once enough pairs of outer-level symbols of each polarity have arrived. The peak detectors, the PLL and the sync correlators lie outside the block.

Top module: `rxacq_seq`

## Requirements
- R1: A synchronous active-high reset makes both sequences idle. After reset both busy flags and the ready flag read 0, and the outputs follow the software selects.
- R2: When a sequence is idle, its output is a registered copy of the software select, one clock behind. The level output is the 2-bit software level code. The bandwidth output is 3 bits wide and equals {1'b0, software bandwidth}.
- R3: The level codes are 00 track, 01 clamp, 10 lossy peak and 11 slow peak. A level trigger gives code 01 and level busy = 1 on the next clock edge. Clamp holds until the first symbol strobe after the trigger, and that strobe moves the output to 10. Between strobes, with no trigger and no frame sync, the level output does not change.
- R4: The output stays at 10 for 15 strobes. The 15th strobe moves it to 11.
- R5: Code 11 has no strobe limit. A frame-sync pulse in this phase ends the sequence: level busy drops and the output returns to the software level code.
- R6: A frame-sync pulse during the clamp or lossy phase has no effect on the level output or on level busy.
- R7: A clock trigger gives bandwidth 100 (extra wide) and clock busy = 1 on the next edge. The output stays 100 for 16 strobes, then becomes 010 (wide).
- R8: The 45th strobe after the clock trigger ends the clock sequence. Clock busy drops and the output returns to {1'b0, software bandwidth}.
- R9: A trigger while its sequence runs restarts that sequence at its first phase. A strobe in the same cycle as a trigger is not counted.
- R10: The two sequences do not affect each other. Their triggers, strobe counts and endings are separate.
- R11: Symbol codes are 01 for +3 and 11 for -3 (00 is +1, 10 is -1). While level busy is 1, each strobe counts non-overlapping pairs of consecutive +3 symbols and of consecutive -3 symbols. Ready rises on the strobe that completes the second pair of the second polarity. A level trigger clears ready and the pair counts. Ready then holds until the next level trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_stb_i | input | 1 | One-cycle pulse per received symbol |
| rx_sym_i | input | 2 | Symbol decision, valid with the strobe |
| lvl_go_i | input | 1 | Level acquisition trigger pulse |
| clk_go_i | input | 1 | Clock acquisition trigger pulse |
| fsync_i | input | 1 | Frame-sync detected pulse |
| sw_lvl_i | input | 2 | Software-selected level mode |
| sw_bw_i | input | 2 | Software-selected PLL bandwidth |
| lvl_mode_o | output | 2 | Effective level mode |
| pll_bw_o | output | 3 | Effective PLL bandwidth |
| lvl_busy_o | output | 1 | Level sequence running |
| clk_busy_o | output | 1 | Clock sequence running |
| lvl_ready_o | output | 1 | Enough outer-level pairs seen |

## Verification
The bench checks the exact strobe on which each phase changes: the 1st, the 15th after clamp, the 16th and the 45th. An off-by-one counter shows up one symbol early or late at those points. It sends frame sync during clamp and lossy, where a design that ends too early would drop busy, and it leaves the slow phase running for a hundred strobes to catch any hidden limit. It retriggers a sequence mid-run, with a strobe in the same cycle as the trigger, to catch a design that keeps its old count or counts that strobe. It sends runs of three +3 symbols to catch a pair counter that lets pairs overlap, which would raise ready one pair early.

// File: rtl/rxacq_pkg.sv
package rxacq_pkg;

  // Effective level-measurement modes
  typedef enum logic [1:0] {
    LVL_TRACK = 2'b00,
    LVL_CLAMP = 2'b01,
    LVL_LOSSY = 2'b10,
    LVL_SLOW  = 2'b11
  } lvl_mode_e;

  // PLL bandwidth codes on the 3-bit effective output
  localparam logic [2:0] BW_XWIDE = 3'b100;
  localparam logic [2:0] BW_WIDE  = 3'b010;

  // Received symbol decisions
  localparam logic [1:0] SYM_P1 = 2'b00;
  localparam logic [1:0] SYM_P3 = 2'b01;
  localparam logic [1:0] SYM_M1 = 2'b10;
  localparam logic [1:0] SYM_M3 = 2'b11;

  typedef enum logic [1:0] {
    LS_IDLE,
    LS_CLAMP,
    LS_LOSSY,
    LS_SLOW
  } lvl_state_e;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_XWIDE,
    CS_WIDE
  } clk_state_e;

endpackage

// File: rtl/rxacq_lvl_seq.sv
module rxacq_lvl_seq
  import rxacq_pkg::*;
#(
  parameter int LOSSY_SYMS = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_stb_i,
  input  logic       start_i,
  input  logic       fsync_i,
  input  logic [1:0] sw_mode_i,
  output logic [1:0] mode_o,
  output logic       busy_o
);

  localparam int CW = $clog2(LOSSY_SYMS + 1);
  localparam logic [CW-1:0] LAST = CW'(LOSSY_SYMS - 1);

  lvl_state_e     st_q, st_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic [1:0]     mode_n;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    if (start_i) begin
      st_n  = LS_CLAMP;
      cnt_n = '0;
    end else begin
      unique case (st_q)
        LS_CLAMP: if (sym_stb_i) begin
          st_n  = LS_LOSSY;
          cnt_n = '0;
        end
        LS_LOSSY: if (sym_stb_i) begin
          if (cnt_q == LAST) begin
            st_n  = LS_SLOW;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        LS_SLOW: if (fsync_i) st_n = LS_IDLE;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (st_n)
      LS_CLAMP: mode_n = LVL_CLAMP;
      LS_LOSSY: mode_n = LVL_LOSSY;
      LS_SLOW:  mode_n = LVL_SLOW;
      default:  mode_n = sw_mode_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= LS_IDLE;
      cnt_q  <= '0;
      mode_o <= sw_mode_i;
      busy_o <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      mode_o <= mode_n;
      busy_o <= (st_n != LS_IDLE);
    end
  end

endmodule

// File: rtl/rxacq_clk_seq.sv
module rxacq_clk_seq
  import rxacq_pkg::*;
#(
  parameter int XWIDE_SYMS = 16,
  parameter int TOTAL_SYMS = 45
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_stb_i,
  input  logic       start_i,
  input  logic [1:0] sw_bw_i,
  output logic [2:0] bw_o,
  output logic       busy_o
);

  localparam int CW = $clog2(TOTAL_SYMS + 1);
  localparam logic [CW-1:0] XW_LAST  = CW'(XWIDE_SYMS - 1);
  localparam logic [CW-1:0] ALL_LAST = CW'(TOTAL_SYMS - 1);

  clk_state_e    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [2:0]    bw_n;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    if (start_i) begin
      st_n  = CS_XWIDE;
      cnt_n = '0;
    end else if (sym_stb_i && st_q != CS_IDLE) begin
      cnt_n = cnt_q + 1'b1;
      if (st_q == CS_XWIDE && cnt_q == XW_LAST) st_n = CS_WIDE;
      if (st_q == CS_WIDE && cnt_q == ALL_LAST) begin
        st_n  = CS_IDLE;
        cnt_n = '0;
      end
    end
  end

  always_comb begin
    unique case (st_n)
      CS_XWIDE: bw_n = BW_XWIDE;
      CS_WIDE:  bw_n = BW_WIDE;
      default:  bw_n = {1'b0, sw_bw_i};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= CS_IDLE;
      cnt_q  <= '0;
      bw_o   <= {1'b0, sw_bw_i};
      busy_o <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      bw_o   <= bw_n;
      busy_o <= (st_n != CS_IDLE);
    end
  end

endmodule

// File: rtl/rxacq_pair_cnt.sv
module rxacq_pair_cnt
  import rxacq_pkg::*;
#(
  parameter int PAIRS_NEEDED = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear_i,
  input  logic       en_i,
  input  logic       sym_stb_i,
  input  logic [1:0] rx_sym_i,
  output logic       ready_o
);

  localparam int PW = $clog2(PAIRS_NEEDED + 1);
  localparam logic [PW-1:0] FULL = PW'(PAIRS_NEEDED);

  logic [PW-1:0] pos_q, pos_n, neg_q, neg_n;
  logic          hp_q, hp_n, hn_q, hn_n;

  always_comb begin
    pos_n = pos_q;
    neg_n = neg_q;
    hp_n  = hp_q;
    hn_n  = hn_q;
    if (clear_i) begin
      pos_n = '0;
      neg_n = '0;
      hp_n  = 1'b0;
      hn_n  = 1'b0;
    end else if (en_i && sym_stb_i) begin
      hp_n = 1'b0;
      hn_n = 1'b0;
      if (rx_sym_i == SYM_P3) begin
        if (hp_q) begin
          if (pos_q != FULL) pos_n = pos_q + 1'b1;
        end else begin
          hp_n = 1'b1;
        end
      end else if (rx_sym_i == SYM_M3) begin
        if (hn_q) begin
          if (neg_q != FULL) neg_n = neg_q + 1'b1;
        end else begin
          hn_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      neg_q   <= '0;
      hp_q    <= 1'b0;
      hn_q    <= 1'b0;
      ready_o <= 1'b0;
    end else begin
      pos_q   <= pos_n;
      neg_q   <= neg_n;
      hp_q    <= hp_n;
      hn_q    <= hn_n;
      ready_o <= (pos_n == FULL) && (neg_n == FULL);
    end
  end

endmodule

// File: rtl/rxacq_seq.sv
module rxacq_seq #(
  parameter int LOSSY_SYMS   = 15,
  parameter int XWIDE_SYMS   = 16,
  parameter int TOTAL_SYMS   = 45,
  parameter int PAIRS_NEEDED = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_stb_i,
  input  logic [1:0] rx_sym_i,
  input  logic       lvl_go_i,
  input  logic       clk_go_i,
  input  logic       fsync_i,
  input  logic [1:0] sw_lvl_i,
  input  logic [1:0] sw_bw_i,
  output logic [1:0] lvl_mode_o,
  output logic [2:0] pll_bw_o,
  output logic       lvl_busy_o,
  output logic       clk_busy_o,
  output logic       lvl_ready_o
);

  rxacq_lvl_seq #(.LOSSY_SYMS(LOSSY_SYMS)) u_lvl (
    .clk       (clk),
    .rst       (rst),
    .sym_stb_i (sym_stb_i),
    .start_i   (lvl_go_i),
    .fsync_i   (fsync_i),
    .sw_mode_i (sw_lvl_i),
    .mode_o    (lvl_mode_o),
    .busy_o    (lvl_busy_o)
  );

  rxacq_clk_seq #(.XWIDE_SYMS(XWIDE_SYMS), .TOTAL_SYMS(TOTAL_SYMS)) u_clk (
    .clk       (clk),
    .rst       (rst),
    .sym_stb_i (sym_stb_i),
    .start_i   (clk_go_i),
    .sw_bw_i   (sw_bw_i),
    .bw_o      (pll_bw_o),
    .busy_o    (clk_busy_o)
  );

  rxacq_pair_cnt #(.PAIRS_NEEDED(PAIRS_NEEDED)) u_pairs (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (lvl_go_i),
    .en_i      (lvl_busy_o),
    .sym_stb_i (sym_stb_i),
    .rx_sym_i  (rx_sym_i),
    .ready_o   (lvl_ready_o)
  );

endmodule

// File: rtl/rxacq_seq_chk.sv
module rxacq_seq_chk
  import rxacq_pkg::*;
#(
  parameter int XWIDE_SYMS = 16,
  parameter int TOTAL_SYMS = 45
) (
  input logic       clk,
  input logic       rst,
  input logic       sym_stb_i,
  input logic       lvl_go_i,
  input logic       clk_go_i,
  input logic       fsync_i,
  input logic [1:0] sw_lvl_i,
  input logic [1:0] sw_bw_i,
  input logic [1:0] lvl_mode_o,
  input logic [2:0] pll_bw_o,
  input logic       lvl_busy_o,
  input logic       clk_busy_o,
  input logic       lvl_ready_o
);

  localparam int CW = $clog2(TOTAL_SYMS + 1);

  // independent count of strobes seen since the last clock trigger
  logic [CW-1:0] seen_q;
  always_ff @(posedge clk) begin
    if (rst || clk_go_i) seen_q <= '0;
    else if (sym_stb_i && clk_busy_o && seen_q != CW'(TOTAL_SYMS)) seen_q <= seen_q + 1'b1;
  end

  assert_idle_level_R2: assert property (@(posedge clk) disable iff (rst)
    !lvl_busy_o |-> lvl_mode_o == $past(sw_lvl_i));
  assert_idle_bw_R2: assert property (@(posedge clk) disable iff (rst)
    !clk_busy_o |-> pll_bw_o == {1'b0, $past(sw_bw_i)});
  assert_trigger_clamp_R3: assert property (@(posedge clk) disable iff (rst)
    lvl_go_i |=> lvl_busy_o && lvl_mode_o == LVL_CLAMP);
  assert_clamp_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    (lvl_busy_o && lvl_mode_o == LVL_CLAMP && sym_stb_i && !lvl_go_i) |=> lvl_mode_o == LVL_LOSSY);
  assert_hold_between_strobes_R3: assert property (@(posedge clk) disable iff (rst)
    (lvl_busy_o && !sym_stb_i && !lvl_go_i && !fsync_i) |=> lvl_busy_o && $stable(lvl_mode_o));
  assert_slow_ends_on_sync_R5: assert property (@(posedge clk) disable iff (rst)
    (lvl_busy_o && lvl_mode_o == LVL_SLOW && fsync_i && !lvl_go_i) |=> !lvl_busy_o);
  assert_early_sync_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (lvl_busy_o && lvl_mode_o != LVL_SLOW && fsync_i && !lvl_go_i) |=> lvl_busy_o);
  assert_trigger_xwide_R7: assert property (@(posedge clk) disable iff (rst)
    clk_go_i |=> clk_busy_o && pll_bw_o == BW_XWIDE);
  assert_xwide_window_R7: assert property (@(posedge clk) disable iff (rst)
    (clk_busy_o && pll_bw_o == BW_XWIDE) |-> seen_q < CW'(XWIDE_SYMS));
  assert_clock_window_R8: assert property (@(posedge clk) disable iff (rst)
    clk_busy_o |-> seen_q < CW'(TOTAL_SYMS));
  assert_ready_on_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl_ready_o) |-> $past(sym_stb_i));

endmodule

bind rxacq_seq rxacq_seq_chk #(.XWIDE_SYMS(XWIDE_SYMS), .TOTAL_SYMS(TOTAL_SYMS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sym_stb_i   (sym_stb_i),
  .lvl_go_i    (lvl_go_i),
  .clk_go_i    (clk_go_i),
  .fsync_i     (fsync_i),
  .sw_lvl_i    (sw_lvl_i),
  .sw_bw_i     (sw_bw_i),
  .lvl_mode_o  (lvl_mode_o),
  .pll_bw_o    (pll_bw_o),
  .lvl_busy_o  (lvl_busy_o),
  .clk_busy_o  (clk_busy_o),
  .lvl_ready_o (lvl_ready_o)
);

// File: tb/rxacq_seq_test.sv
module rxacq_seq_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sym_stb_i = 1'b0;
  logic [1:0] rx_sym_i = 2'b00;
  logic       lvl_go_i = 1'b0;
  logic       clk_go_i = 1'b0;
  logic       fsync_i = 1'b0;
  logic [1:0] sw_lvl_i = 2'b00;
  logic [1:0] sw_bw_i = 2'b01;
  logic [1:0] lvl_mode_o;
  logic [2:0] pll_bw_o;
  logic       lvl_busy_o, clk_busy_o, lvl_ready_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  rxacq_seq uut (
    .clk(clk), .rst(rst), .sym_stb_i(sym_stb_i), .rx_sym_i(rx_sym_i),
    .lvl_go_i(lvl_go_i), .clk_go_i(clk_go_i), .fsync_i(fsync_i),
    .sw_lvl_i(sw_lvl_i), .sw_bw_i(sw_bw_i), .lvl_mode_o(lvl_mode_o),
    .pll_bw_o(pll_bw_o), .lvl_busy_o(lvl_busy_o), .clk_busy_o(clk_busy_o),
    .lvl_ready_o(lvl_ready_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic stb(input logic [1:0] s);
    sym_stb_i = 1'b1; rx_sym_i = s;
    tick();
    sym_stb_i = 1'b0; rx_sym_i = 2'b00;
  endtask

  task automatic stbs(input int n);
    for (int i = 0; i < n; i++) stb(2'b00);
  endtask

  task automatic go_lvl();
    lvl_go_i = 1'b1; tick(); lvl_go_i = 1'b0;
  endtask

  task automatic go_clk();
    clk_go_i = 1'b1; tick(); clk_go_i = 1'b0;
  endtask

  task automatic sync();
    fsync_i = 1'b1; tick(); fsync_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; repeat (3) tick(); rst = 1'b0; tick();
    chk("R1 level mode", lvl_mode_o, 0);
    chk("R1 bw", pll_bw_o, 1);
    chk("R1 busy", {lvl_busy_o, clk_busy_o, lvl_ready_o}, 0);
    sw_lvl_i = 2'b10; sw_bw_i = 2'b11; tick();
    chk("R2 level follows sw", lvl_mode_o, 2);
    chk("R2 bw follows sw", pll_bw_o, 3);
    sw_lvl_i = 2'b00; sw_bw_i = 2'b00; tick();
  endtask

  task automatic t_level();
    go_lvl();
    chk("R3 clamp on trigger", lvl_mode_o, 1);
    chk("R3 busy", lvl_busy_o, 1);
    repeat (5) tick();
    chk("R3 clamp holds without strobe", lvl_mode_o, 1);
    sync();
    chk("R6 sync in clamp", {lvl_busy_o, lvl_mode_o}, 5);
    stb(2'b00);
    chk("R3 lossy after 1 strobe", lvl_mode_o, 2);
    stbs(7); sync(); stbs(7);
    chk("R6 sync in lossy", {lvl_busy_o, lvl_mode_o}, 6);
    chk("R4 lossy after 14", lvl_mode_o, 2);
    stb(2'b00);
    chk("R4 slow after 15", lvl_mode_o, 3);
    stbs(100);
    chk("R5 slow without limit", {lvl_busy_o, lvl_mode_o}, 7);
    sync();
    chk("R5 end on sync", {lvl_busy_o, lvl_mode_o}, 0);
  endtask

  task automatic t_clock();
    go_clk();
    chk("R7 xwide on trigger", {clk_busy_o, pll_bw_o}, 12);
    stbs(15);
    chk("R7 xwide after 15", pll_bw_o, 4);
    stb(2'b00);
    chk("R7 wide after 16", pll_bw_o, 2);
    stbs(28);
    chk("R8 wide after 44", {clk_busy_o, pll_bw_o}, 10);
    stb(2'b00);
    chk("R8 sw after 45", {clk_busy_o, pll_bw_o}, 0);
  endtask

  task automatic t_retrig();
    go_lvl(); stbs(6);
    chk("R9 lossy before retrigger", lvl_mode_o, 2);
    lvl_go_i = 1'b1; sym_stb_i = 1'b1; tick(); lvl_go_i = 1'b0; sym_stb_i = 1'b0;
    chk("R9 restart in clamp", lvl_mode_o, 1);
    stb(2'b00); stbs(14);
    chk("R9 lossy after restart 14", lvl_mode_o, 2);
    stb(2'b00);
    chk("R9 slow after restart", lvl_mode_o, 3);
    sync();
    go_clk(); stbs(30);
    clk_go_i = 1'b1; sym_stb_i = 1'b1; tick(); clk_go_i = 1'b0; sym_stb_i = 1'b0;
    chk("R9 clock restart", pll_bw_o, 4);
    stbs(44);
    chk("R9 clock busy at 44", clk_busy_o, 1);
    stb(2'b00);
    chk("R9 clock ends at 45", clk_busy_o, 0);
  endtask

  task automatic t_indep();
    sw_bw_i = 2'b01;
    lvl_go_i = 1'b1; clk_go_i = 1'b1; tick(); lvl_go_i = 1'b0; clk_go_i = 1'b0;
    stbs(16);
    chk("R10 level slow", lvl_mode_o, 3);
    chk("R10 clock wide", pll_bw_o, 2);
    sync();
    chk("R10 level ends alone", {lvl_busy_o, clk_busy_o}, 1);
    chk("R10 clock unchanged", pll_bw_o, 2);
    stbs(29);
    chk("R10 clock ends", {clk_busy_o, pll_bw_o}, 1);
  endtask

  task automatic t_ready();
    go_lvl();
    chk("R11 ready clear after trigger", lvl_ready_o, 0);
    stb(2'b01); stb(2'b01); stb(2'b01); stb(2'b00); stb(2'b01); stb(2'b01);
    stb(2'b11); stb(2'b11); stb(2'b11); stb(2'b01);
    chk("R11 not ready one neg pair", lvl_ready_o, 0);
    stb(2'b11); stb(2'b11);
    chk("R11 ready after 2+2 pairs", lvl_ready_o, 1);
    sync();
    chk("R11 ready holds after end", lvl_ready_o, 1);
    go_lvl();
    chk("R11 ready cleared by trigger", lvl_ready_o, 0);
    stb(2'b01); stb(2'b01); stb(2'b01);
    stb(2'b11); stb(2'b11); stb(2'b11); stb(2'b11);
    chk("R11 no overlapping pairs", lvl_ready_o, 0);
    stb(2'b01);
    chk("R11 single +3 not a pair", lvl_ready_o, 0);
    stb(2'b01);
    chk("R11 ready after second pos pair", lvl_ready_o, 1);
    sync();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick();
    t_reset();
    t_level();
    t_clock();
    t_retrig();
    t_indep();
    t_ready();
    repeat (3) tick();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule